// File: doc/BRIEF.md
# General-Purpose I/O Port with Input Synchronizer

This block is an eight-bit bidirectional I/O port for a small microcontroller. Software sets a direction register and an output register through a single address/write/read register port. Each bit of the direction register picks whether that pin drives or listens. When a pin is an output, the output register supplies the level it drives. When a pin is an input, the same output register bit turns on its weak pull-up.

Every pad input goes through a two-stage synchronizer before software can read it. The first stage keeps the pad level it sees at each falling clock edge. This is the same as a latch that is transparent while the clock is high and closed while it is low. The second stage loads that held value into the pin-value register at the next rising edge. So an asynchronous change on a pad appears in the register between half a cycle and one and a half cycles after it happens. A level that software itself drives onto the pad reads back one full cycle after the write takes effect.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after it is released with no write, the direction, output and pin-value registers all read 0, pad_oe is 0 and pad_pu is 0.
- R2: Address 1 reads and writes the direction register, and address 2 reads and writes the output register. Address 0 reads the pin-value register, and a write to address 0 changes no register. Address 3 reads 0. A write takes effect at the rising edge where wr_en is high.
- R3: For every bit, pad_oe equals the direction bit (1 = output) and pad_out equals the output-register bit.
- R4: For every bit, pad_pu is 1 only when the direction bit is 0 and the output-register bit is 1.
- R5: The pin-value register follows pad_in for every bit, whatever the direction setting.
- R6: A pad change that arrives just after a falling edge is first seen in the pin-value register at the second rising edge after it, about one and a half cycles later.
- R7: A pad change that arrives while the clock is high is seen at the first rising edge after the next falling edge. If it arrives just after a rising edge this is about one cycle. If it arrives just before a falling edge this is about half a cycle.
- R8: When software drives a pad through a write, a read of the pin-value register in the cycle after the write edge returns the old level. From the next rising edge on, the read returns the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for addr |
| pad_in | input | 8 | Level seen at each pad |
| pad_out | output | 8 | Level driven when the pad is an output |
| pad_oe | output | 8 | Pad output enable per bit |
| pad_pu | output | 8 | Pad pull-up enable per bit |

## Verification
Register and pad-control results show up straight after the rising edge that performs a write, so the bench drives writes at a falling edge and samples one nanosecond after the next rising edge. Pin-value results depend on when a pad changes within the cycle. The bench places each change 0.1 ns after a falling edge, 0.1 ns after a rising edge, or 0.1 ns before a falling edge. For each placement it samples just after the rising edge where the change is due, and also just after the rising edge before that, to confirm the old value is still there. For software loopback, the bench reads at the falling edge inside the write cycle and again after the following rising edge.

// File: rtl/gpio_port.sv
`timescale 1ns/10ps
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  localparam logic [1:0] A_PIN = 2'd0, A_DIR = 2'd1, A_OUT = 2'd2;

  logic [W-1:0] dir_q, out_q, hold_q, pin_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      if (addr == A_DIR) dir_q <= wr_data;
      if (addr == A_OUT) out_q <= wr_data;
    end

  // first stage: level present when the clock falls (transparent-high latch equivalent)
  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) hold_q <= '0;
    else        hold_q <= pad_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= '0;
    else        pin_q <= hold_q;

  assign pad_oe  = dir_q;
  assign pad_out = out_q;
  assign pad_pu  = ~dir_q & out_q;

  always_comb
    case (addr)
      A_PIN:   rd_data = pin_q;
      A_DIR:   rd_data = dir_q;
      A_OUT:   rd_data = out_q;
      default: rd_data = '0;
    endcase

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> dir_q == $past(wr_data));
  a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_OUT) |=> out_q == $past(wr_data));
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_DIR) |=> $stable(dir_q));
  a_r2_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_OUT) |=> $stable(out_q));
  a_r4_pu_never_driving: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
  a_r5_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
    pin_q == $past(hold_q));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/10ps
module test_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data, pad_out, pad_oe, pad_pu, pad_in;
  logic [7:0] ext = '0;
  int vecs = 0, errs = 0;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_port i_gpio_port (.clk, .rst_n, .addr, .wr_en, .wr_data, .rd_data,
                         .pad_in, .pad_out, .pad_oe, .pad_pu);

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a; #0.5; chk(tag, rd_data, exp);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #1;
    rd(2'd1, 8'h00, "R1 dir in reset");
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 pu in reset", pad_pu, 8'h00);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    rd(2'd0, 8'h00, "R1 pin after reset");
    rd(2'd1, 8'h00, "R1 dir after reset");
    rd(2'd2, 8'h00, "R1 out after reset");

    // R3 R4: sweep every direction against several output patterns
    for (int d = 0; d < 256; d++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] o;
        o = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'hA5 : 8'(d * 7 + 3);
        wr(2'd1, 8'(d));
        wr(2'd2, o);
        rd(2'd1, 8'(d), "R2 dir readback");
        rd(2'd2, o, "R2 out readback");
        chk("R3 oe", pad_oe, 8'(d));
        chk("R3 out", pad_out, o);
        chk("R4 pullup", pad_pu, ~8'(d) & o);
      end
    end

    // R2: address 0 write ignored, address 3 reads zero
    wr(2'd1, 8'h3C); wr(2'd2, 8'hC3);
    wr(2'd0, 8'hFF);
    rd(2'd1, 8'h3C, "R2 dir after pin write");
    rd(2'd2, 8'hC3, "R2 out after pin write");
    rd(2'd3, 8'h00, "R2 unused address");

    // R5: all inputs, exhaustive pad patterns
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); #0.1; ext = 8'(v);
      repeat (2) @(posedge clk); #1;
      rd(2'd0, 8'(v), "R5 input pin");
    end
    // R5: mixed directions, output bits read back their driven level
    wr(2'd2, 8'h96);
    for (int d = 0; d < 256; d += 17) begin
      wr(2'd1, 8'(d));
      ext = 8'h5A;
      repeat (2) @(posedge clk); #1;
      rd(2'd0, (8'(d) & 8'h96) | (~8'(d) & 8'h5A), "R5 mixed pins");
    end
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    ext = 8'h00; repeat (3) @(posedge clk);

    // R6: change just after falling edge -> second rising edge
    @(negedge clk); #0.1; ext = 8'hFF;
    @(posedge clk); #1; rd(2'd0, 8'h00, "R6 not yet at first rise");
    @(posedge clk); #1; rd(2'd0, 8'hFF, "R6 seen at second rise");

    // R7: change just after rising edge -> next rising edge
    @(posedge clk); #0.1; ext = 8'h0F;
    #1; rd(2'd0, 8'hFF, "R7 old level same cycle");
    @(posedge clk); #1; rd(2'd0, 8'h0F, "R7 after one cycle");

    // R7: change just before falling edge -> half a cycle
    @(posedge clk); #2.4; ext = 8'hF0;
    @(posedge clk); #1; rd(2'd0, 8'hF0, "R7 after half cycle");

    // R8: software drives the pad
    ext = 8'h00;
    wr(2'd1, 8'hFF);
    repeat (2) @(posedge clk); #1;
    rd(2'd0, 8'h00, "R8 start level");
    @(negedge clk); addr = 2'd2; wr_data = 8'h5A; wr_en = 1'b1;
    @(posedge clk); #0.1; wr_en = 1'b0; addr = 2'd0;
    @(negedge clk); #0.5; chk("R8 old level in write cycle", rd_data, 8'h00);
    @(posedge clk); #1; chk("R8 new level one cycle later", rd_data, 8'h5A);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule